// File: doc/BRIEF.md
# Change-of-Flow Trace Capture Controller

This block records change-of-flow (COF) events into a small trace FIFO. Each event carries a target address and a flag saying whether the access went through the program-page window. An 8-bit control register sets the behaviour. Its fields enable the unit, arm the capture, choose whether a break request is a tag or a force request, permit CPU break requests, and select loop-suppression capture. A secure input blocks the unit from being enabled. The FIFO fills in arrival order, and its entries can be read through an index port. The stored-entry count and a full flag are visible at the ports.

In loop-suppression mode a single comparator register, called comparator C, remembers the last address that was stored. An event whose address equals the comparator value is dropped, with no write and no count change. An event with a different address is stored and also reloaded into the comparator. Tight loops therefore take one FIFO slot per distinct jump and do not fill the buffer. Filling the FIFO ends the trace run. The arm bit then drops and, if break requests are allowed, a one-cycle break request is issued. A comparator C hit signalled from outside also raises a break request when break requests are allowed.

Two resets act on the control register. The power-on reset clears everything. The end-of-trace reset clears only arm and break-enable when the unit is enabled and the begin-trigger input is low; in every other case it clears the whole register.

Top module: `cof_trace_capture`

## Requirements
- R1: After power-on reset the control register reads 0x00, the count is 0, the full flag is 0 and no break request is present.
- R2: Control register fields are: bit 7 enable, bit 6 arm, bit 5 tag-select (1 = tag, 0 = force), bit 4 break-enable, bit 0 loop-capture. Bits 3..1 always read 0.
- R3: While `secure` is high the enable bit is cleared at the next clock edge, and a write cannot set it.
- R4: An event is stored only when `cof_valid`, enable and arm are all 1 in that cycle. Otherwise the count does not change.
- R5: In normal capture each stored event goes to index = current count, and the count rises by one at the same edge. Entries keep their arrival order.
- R6: In loop-capture mode, an event whose address equals the valid comparator C address is not written, and the count does not change.
- R7: In loop-capture mode, an event whose address differs is written, and its address and page flag are loaded into comparator C at the same edge.
- R8: When a register write takes arm from 0 to 1, the count is reset to 0 and comparator C is invalidated. The first event of the run is therefore always stored.
- R9: While `event_only` is high the loop-capture bit has no effect, and repeated addresses are all stored.
- R10: The count saturates at DEPTH (8) and `fifo_full` is then 1. The write that fills the FIFO ends the run and clears arm at the same edge. Later events are ignored.
- R11: When break-enable and enable are 1, the end of a run or a `cmpc_hit` cycle gives `brk_req` high for exactly one cycle after that edge. `brk_tag` equals the tag-select bit during that cycle.
- R12: When break-enable is 0, `brk_req` and `brk_tag` stay 0 whatever the tag-select bit is set to.
- R13: A `trace_rst` pulse with enable 1 and `begin_trig` 0 clears only arm and break-enable. With enable 0 or `begin_trig` 1 it clears the whole register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| trace_rst | input | 1 | End-of-trace reset pulse |
| begin_trig | input | 1 | Begin-trigger mode; 0 selects the partial end-of-trace reset |
| secure | input | 1 | Secure state; blocks the enable bit |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| cof_valid | input | 1 | COF event present |
| cof_addr | input | ADDR_W | COF target address |
| cof_ppage | input | 1 | COF program-page access flag |
| event_only | input | 1 | Capture mode is event-only |
| cmpc_hit | input | 1 | Comparator C hit from the bus compare logic |
| cmpc_addr | output | ADDR_W | Comparator C address |
| cmpc_ppage | output | 1 | Comparator C page flag |
| cmpc_valid | output | 1 | Comparator C holds a value |
| fifo_count | output | $clog2(DEPTH+1) | Stored entry count |
| fifo_full | output | 1 | FIFO holds DEPTH entries |
| rd_idx | input | $clog2(DEPTH) | FIFO read index |
| rd_addr | output | ADDR_W | Address at `rd_idx` |
| rd_ppage | output | 1 | Page flag at `rd_idx` |
| brk_req | output | 1 | One-cycle CPU break request |
| brk_tag | output | 1 | 1 = tag request, 0 = force request |

## Verification
A wrong comparator C value shows up within one event. Either a repeated address adds to `fifo_count`, or a new address is dropped. The bench checks this right after each event, not only at the end of the run. A mistimed end-of-run shows one cycle later, as a wrong arm bit in `reg_rdata` or a `brk_req` that is missing or longer than one cycle. A stale count after re-arming shows on the first event of the next run. The bench sweeps every fill level, both tag settings and all the reset variants against values it computes itself.

// File: rtl/cof_trace_pkg.sv
package cof_trace_pkg;
   localparam int CTL_W    = 8;
   localparam int CTL_EN   = 7;
   localparam int CTL_ARM  = 6;
   localparam int CTL_TAG  = 5;
   localparam int CTL_BRK  = 4;
   localparam int CTL_LOOP = 0;

   typedef struct packed {
      logic en;
      logic arm;
      logic tag;
      logic brk;
      logic loop;
   } ctl_t;

   localparam ctl_t CTL_CLEAR = '{en: 1'b0, arm: 1'b0, tag: 1'b0, brk: 1'b0, loop: 1'b0};
endpackage

// File: rtl/cof_ctl_reg.sv
module cof_ctl_reg
   import cof_trace_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trace_rst,
   input  logic             begin_trig,
   input  logic             secure,
   input  logic             reg_we,
   input  logic [CTL_W-1:0] reg_wdata,
   input  logic             end_run,
   output ctl_t             ctl,
   output logic             arm_rise,
   output logic [CTL_W-1:0] rdata
);
   ctl_t ctl_q;
   ctl_t ctl_d;

   always_comb begin
      ctl_d = ctl_q;
      if (reg_we) begin
         ctl_d.en   = reg_wdata[CTL_EN];
         ctl_d.arm  = reg_wdata[CTL_ARM];
         ctl_d.tag  = reg_wdata[CTL_TAG];
         ctl_d.brk  = reg_wdata[CTL_BRK];
         ctl_d.loop = reg_wdata[CTL_LOOP];
      end
      if (end_run) begin
         ctl_d.arm = 1'b0;
      end
      if (trace_rst) begin
         if (ctl_q.en && !begin_trig) begin
            ctl_d     = ctl_q;
            ctl_d.arm = 1'b0;
            ctl_d.brk = 1'b0;
         end else begin
            ctl_d = CTL_CLEAR;
         end
      end
      if (secure) begin
         ctl_d.en = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= CTL_CLEAR;
      end else begin
         ctl_q <= ctl_d;
      end
   end

   assign arm_rise = ctl_d.arm & ~ctl_q.arm;
   assign ctl      = ctl_q;

   always_comb begin
      rdata           = '0;
      rdata[CTL_EN]   = ctl_q.en;
      rdata[CTL_ARM]  = ctl_q.arm;
      rdata[CTL_TAG]  = ctl_q.tag;
      rdata[CTL_BRK]  = ctl_q.brk;
      rdata[CTL_LOOP] = ctl_q.loop;
   end
endmodule

// File: rtl/cof_loop_cmp.sv
module cof_loop_cmp #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              load,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic              in_ppage,
   output logic              match,
   output logic [ADDR_W-1:0] q_addr,
   output logic              q_ppage,
   output logic              q_valid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_addr  <= '0;
         q_ppage <= 1'b0;
         q_valid <= 1'b0;
      end else if (clear) begin
         q_addr  <= '0;
         q_ppage <= 1'b0;
         q_valid <= 1'b0;
      end else if (load) begin
         q_addr  <= in_addr;
         q_ppage <= in_ppage;
         q_valid <= 1'b1;
      end
   end

   assign match = q_valid && (q_addr == in_addr);
endmodule

// File: rtl/cof_capture_fifo.sv
module cof_capture_fifo #(
   parameter int ADDR_W = 16,
   parameter int DEPTH  = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic                       wr,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic                       wr_ppage,
   input  logic [$clog2(DEPTH)-1:0]   rd_idx,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic                       full,
   output logic                       end_run,
   output logic [ADDR_W-1:0]          rd_addr,
   output logic                       rd_ppage
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam int IW = $clog2(DEPTH);
   localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);
   localparam logic [CW-1:0] TOP  = CW'(DEPTH);

   logic [ADDR_W-1:0] mem_addr  [DEPTH];
   logic              mem_ppage [DEPTH];
   logic [CW-1:0]     cnt_q;
   logic              accept;

   assign full    = (cnt_q == TOP);
   assign accept  = wr & ~full;
   assign end_run = accept & (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (flush) begin
         cnt_q <= '0;
      end else if (accept) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem_addr[i]  <= '0;
            mem_ppage[i] <= 1'b0;
         end else if (accept && (cnt_q == CW'(i))) begin
            mem_addr[i]  <= wr_addr;
            mem_ppage[i] <= wr_ppage;
         end
      end
   end

   always_comb begin
      rd_addr  = '0;
      rd_ppage = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (rd_idx == IW'(i)) begin
            rd_addr  = mem_addr[i];
            rd_ppage = mem_ppage[i];
         end
      end
   end

   assign count = cnt_q;
endmodule

// File: rtl/cof_brk_gen.sv
module cof_brk_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic brk_en,
   input  logic tag_sel,
   input  logic end_run,
   input  logic cmpc_hit,
   output logic brk_req,
   output logic brk_tag
);
   logic fire;

   assign fire = enable & brk_en & (end_run | cmpc_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         brk_req <= 1'b0;
         brk_tag <= 1'b0;
      end else begin
         brk_req <= fire;
         brk_tag <= fire & tag_sel;
      end
   end
endmodule

// File: rtl/cof_trace_capture.sv
module cof_trace_capture
   import cof_trace_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DEPTH    = 8,
   parameter bit HAS_LOOP = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       trace_rst,
   input  logic                       begin_trig,
   input  logic                       secure,
   input  logic                       reg_we,
   input  logic [7:0]                 reg_wdata,
   output logic [7:0]                 reg_rdata,
   input  logic                       cof_valid,
   input  logic [ADDR_W-1:0]          cof_addr,
   input  logic                       cof_ppage,
   input  logic                       event_only,
   input  logic                       cmpc_hit,
   output logic [ADDR_W-1:0]          cmpc_addr,
   output logic                       cmpc_ppage,
   output logic                       cmpc_valid,
   output logic [$clog2(DEPTH+1)-1:0] fifo_count,
   output logic                       fifo_full,
   input  logic [$clog2(DEPTH)-1:0]   rd_idx,
   output logic [ADDR_W-1:0]          rd_addr,
   output logic                       rd_ppage,
   output logic                       brk_req,
   output logic                       brk_tag
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("cof_trace_capture: DEPTH must be at least 2");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("cof_trace_capture: ADDR_W must be positive");
   end
   if (CTL_W != 8) begin : g_bad_ctl
      $error("cof_trace_capture: control register must be 8 bits");
   end

   ctl_t ctl;
   logic arm_rise;
   logic end_run;
   logic loop_act;
   logic capture;
   logic suppress;
   logic do_write;
   logic cmp_match;

   cof_ctl_reg u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .trace_rst  (trace_rst),
      .begin_trig (begin_trig),
      .secure     (secure),
      .reg_we     (reg_we),
      .reg_wdata  (reg_wdata),
      .end_run    (end_run),
      .ctl        (ctl),
      .arm_rise   (arm_rise),
      .rdata      (reg_rdata)
   );

   assign capture  = cof_valid & ctl.arm & ctl.en & ~fifo_full;
   assign suppress = loop_act & cmp_match;
   assign do_write = capture & ~suppress;

   if (HAS_LOOP) begin : g_loop
      assign loop_act = ctl.loop & ~event_only;
      cof_loop_cmp #(.ADDR_W(ADDR_W)) u_cmp (
         .clk      (clk),
         .rst_n    (rst_n),
         .clear    (arm_rise),
         .load     (do_write & loop_act),
         .in_addr  (cof_addr),
         .in_ppage (cof_ppage),
         .match    (cmp_match),
         .q_addr   (cmpc_addr),
         .q_ppage  (cmpc_ppage),
         .q_valid  (cmpc_valid)
      );
   end else begin : g_noloop
      assign loop_act   = 1'b0;
      assign cmp_match  = 1'b0;
      assign cmpc_addr  = '0;
      assign cmpc_ppage = 1'b0;
      assign cmpc_valid = 1'b0;
   end

   cof_capture_fifo #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (arm_rise),
      .wr       (do_write),
      .wr_addr  (cof_addr),
      .wr_ppage (cof_ppage),
      .rd_idx   (rd_idx),
      .count    (fifo_count),
      .full     (fifo_full),
      .end_run  (end_run),
      .rd_addr  (rd_addr),
      .rd_ppage (rd_ppage)
   );

   cof_brk_gen u_brk (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (ctl.en),
      .brk_en   (ctl.brk),
      .tag_sel  (ctl.tag),
      .end_run  (end_run),
      .cmpc_hit (cmpc_hit),
      .brk_req  (brk_req),
      .brk_tag  (brk_tag)
   );
endmodule

// File: rtl/cof_trace_chk.sv
module cof_trace_chk #(
   parameter int DEPTH = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       secure,
   input logic                       cof_valid,
   input logic [7:0]                 reg_rdata,
   input logic [$clog2(DEPTH+1)-1:0] fifo_count,
   input logic                       fifo_full,
   input logic                       brk_req,
   input logic                       brk_tag
);
   localparam int CW = $clog2(DEPTH + 1);

   assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[3:1] == 3'b000);

   assert_secure_blocks_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
      secure |=> !reg_rdata[7]);

   assert_capture_needs_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_count == $past(fifo_count) + CW'(1)) |-> $past(reg_rdata[6] && reg_rdata[7] && cof_valid));

   assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_count != $past(fifo_count)) |-> (fifo_count == $past(fifo_count) + CW'(1) || fifo_count == '0));

   assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_count <= CW'(DEPTH));

   assert_full_disarms_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fifo_full) |-> !reg_rdata[6]);

   assert_brk_needs_enable_R12: assert property (@(posedge clk) disable iff (!rst_n)
      brk_req |-> $past(reg_rdata[4] && reg_rdata[7]));

   assert_tag_with_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
      brk_tag |-> brk_req);
endmodule

bind cof_trace_capture cof_trace_chk #(.DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .secure     (secure),
   .cof_valid  (cof_valid),
   .reg_rdata  (reg_rdata),
   .fifo_count (fifo_count),
   .fifo_full  (fifo_full),
   .brk_req    (brk_req),
   .brk_tag    (brk_tag)
);

// File: tb/cof_trace_capture_tb.sv
`timescale 1ns/1ps
module cof_trace_capture_tb;
   localparam int AW = 16;
   localparam int DEPTH = 8;
   localparam int CW = $clog2(DEPTH + 1);
   localparam int IW = $clog2(DEPTH);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trace_rst = 1'b0, begin_trig = 1'b0, secure = 1'b0;
   logic reg_we = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic cof_valid = 1'b0, cof_ppage = 1'b0, event_only = 1'b0, cmpc_hit = 1'b0;
   logic [AW-1:0] cof_addr = '0;
   logic [AW-1:0] cmpc_addr;
   logic cmpc_ppage, cmpc_valid;
   logic [CW-1:0] fifo_count;
   logic fifo_full;
   logic [IW-1:0] rd_idx = '0;
   logic [AW-1:0] rd_addr;
   logic rd_ppage, brk_req, brk_tag;

   int n_chk = 0;
   int n_fail = 0;
   int brk_cnt = 0;
   int tag_cnt = 0;
   logic done = 1'b0;

   always #2.5 clk = ~clk;

   cof_trace_capture #(.ADDR_W(AW), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .trace_rst(trace_rst), .begin_trig(begin_trig),
      .secure(secure), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cof_valid(cof_valid), .cof_addr(cof_addr), .cof_ppage(cof_ppage),
      .event_only(event_only), .cmpc_hit(cmpc_hit), .cmpc_addr(cmpc_addr),
      .cmpc_ppage(cmpc_ppage), .cmpc_valid(cmpc_valid), .fifo_count(fifo_count),
      .fifo_full(fifo_full), .rd_idx(rd_idx), .rd_addr(rd_addr), .rd_ppage(rd_ppage),
      .brk_req(brk_req), .brk_tag(brk_tag)
   );

   always @(negedge clk) begin
      if (brk_req) brk_cnt++;
      if (brk_tag) tag_cnt++;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [7:0] v);
      @(negedge clk);
      reg_we = 1'b1;
      reg_wdata = v;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic cof(input logic [AW-1:0] a, input logic p);
      @(negedge clk);
      cof_valid = 1'b1;
      cof_addr = a;
      cof_ppage = p;
      @(negedge clk);
      cof_valid = 1'b0;
   endtask

   task automatic chk_entry(input int idx, input logic [AW-1:0] a, input logic p, input string req);
      rd_idx = IW'(idx);
      #0.5;
      chk(rd_addr == a && rd_ppage == p, req, {rd_ppage, rd_addr}, {p, a});
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   function automatic logic [AW-1:0] fill_addr(input int i);
      return AW'(16'h1000 + i * 16'h0111);
   endfunction

   task automatic fill_run(input logic [7:0] ctl, input int exp_brk, input int exp_tag, input string req);
      int b0, t0;
      wr_reg(ctl);
      b0 = brk_cnt;
      t0 = tag_cnt;
      for (int i = 0; i < DEPTH; i++) begin
         cof(fill_addr(i), i[0]);
         chk(fifo_count == CW'(i + 1), "R5", fifo_count, i + 1);
         chk(fifo_full == (i == DEPTH - 1), "R10", fifo_full, i == DEPTH - 1);
      end
      idle(3);
      chk(brk_cnt - b0 == exp_brk, req, brk_cnt - b0, exp_brk);
      chk(tag_cnt - t0 == exp_tag, req, tag_cnt - t0, exp_tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] seq_a [7];
      logic          seq_p [7];
      int            exp_cnt;
      logic [AW-1:0] last_a;
      logic          last_v;
      logic [AW-1:0] st_a [8];
      logic          st_p [8];
      int            b0;

      idle(3);
      // R1: power-on state
      chk(reg_rdata == 8'h00, "R1", reg_rdata, 0);
      chk(fifo_count == '0 && !fifo_full, "R1", {fifo_full, fifo_count}, 0);
      chk(!brk_req && !brk_tag, "R1", {brk_req, brk_tag}, 0);
      rst_n = 1'b1;
      idle(2);

      // R2: field layout, reserved bits read zero
      wr_reg(8'h0E);
      chk(reg_rdata == 8'h00, "R2", reg_rdata, 8'h00);
      wr_reg(8'hBF);
      chk(reg_rdata == 8'hB1, "R2", reg_rdata, 8'hB1);
      wr_reg(8'h00);

      // R3: secure blocks enable
      wr_reg(8'h80);
      chk(reg_rdata == 8'h80, "R3", reg_rdata, 8'h80);
      secure = 1'b1;
      idle(1);
      chk(reg_rdata[7] == 1'b0, "R3", reg_rdata, 8'h00);
      wr_reg(8'h90);
      chk(reg_rdata == 8'h10, "R3", reg_rdata, 8'h10);
      secure = 1'b0;
      wr_reg(8'h00);

      // R4: arm without enable stores nothing
      wr_reg(8'h40);
      cof(16'h0042, 1'b1);
      chk(fifo_count == '0, "R4", fifo_count, 0);
      wr_reg(8'h80);
      cof(16'h0043, 1'b0);
      chk(fifo_count == '0, "R4", fifo_count, 0);

      // R5, R10, R12: normal fill, breaks disabled with tag set
      fill_run(8'hE0, 0, 0, "R12");
      chk(reg_rdata == 8'hA0, "R10", reg_rdata, 8'hA0);
      for (int i = 0; i < DEPTH; i++) chk_entry(i, fill_addr(i), i[0], "R5");
      cof(16'hBEEF, 1'b1);
      chk(fifo_count == CW'(DEPTH), "R10", fifo_count, DEPTH);
      chk_entry(DEPTH - 1, fill_addr(DEPTH - 1), 1'b1, "R10");

      // R8: re-arm resets count; R11 tag and force break
      fill_run(8'hF0, 1, 1, "R11");
      chk(reg_rdata == 8'hB0, "R10", reg_rdata, 8'hB0);
      fill_run(8'hD0, 1, 0, "R11");
      wr_reg(8'h80);
      wr_reg(8'hC0);
      chk(fifo_count == '0, "R8", fifo_count, 0);

      // R11/R12: comparator C hit break
      wr_reg(8'h90);
      b0 = brk_cnt;
      @(negedge clk) cmpc_hit = 1'b1;
      @(negedge clk) cmpc_hit = 1'b0;
      chk(brk_req == 1'b1, "R11", brk_req, 1);
      idle(2);
      chk(brk_cnt - b0 == 1, "R11", brk_cnt - b0, 1);
      wr_reg(8'hA0);
      b0 = brk_cnt;
      @(negedge clk) cmpc_hit = 1'b1;
      @(negedge clk) cmpc_hit = 1'b0;
      idle(2);
      chk(brk_cnt - b0 == 0, "R12", brk_cnt - b0, 0);

      // R6, R7, R8: loop capture
      seq_a = '{16'h0000, 16'h0000, 16'h0000, 16'h0012, 16'h0012, 16'h0000, 16'h0034};
      seq_p = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
      wr_reg(8'h80);
      wr_reg(8'hC1);
      chk(!cmpc_valid, "R8", cmpc_valid, 0);
      exp_cnt = 0;
      last_v = 1'b0;
      last_a = '0;
      for (int i = 0; i < 7; i++) begin
         cof(seq_a[i], seq_p[i]);
         if (!(last_v && last_a == seq_a[i])) begin
            st_a[exp_cnt] = seq_a[i];
            st_p[exp_cnt] = seq_p[i];
            exp_cnt++;
            last_a = seq_a[i];
            last_v = 1'b1;
            chk(cmpc_addr == seq_a[i] && cmpc_ppage == seq_p[i] && cmpc_valid, "R7",
                {cmpc_ppage, cmpc_addr}, {seq_p[i], seq_a[i]});
         end
         chk(fifo_count == CW'(exp_cnt), "R6", fifo_count, exp_cnt);
      end
      for (int i = 0; i < exp_cnt; i++) chk_entry(i, st_a[i], st_p[i], "R7");

      // R9: event-only ignores loop bit
      wr_reg(8'h81);
      wr_reg(8'hC1);
      event_only = 1'b1;
      cof(16'h0055, 1'b0);
      cof(16'h0055, 1'b0);
      cof(16'h0055, 1'b1);
      chk(fifo_count == CW'(3), "R9", fifo_count, 3);
      event_only = 1'b0;
      cof(16'h0055, 1'b0);
      chk(fifo_count == CW'(4), "R9", fifo_count, 4);

      // R13: end-of-trace reset variants
      wr_reg(8'hF1);
      @(negedge clk) trace_rst = 1'b1; begin_trig = 1'b0;
      @(negedge clk) trace_rst = 1'b0;
      chk(reg_rdata == 8'hA1, "R13", reg_rdata, 8'hA1);
      @(negedge clk) trace_rst = 1'b1; begin_trig = 1'b1;
      @(negedge clk) trace_rst = 1'b0; begin_trig = 1'b0;
      chk(reg_rdata == 8'h00, "R13", reg_rdata, 8'h00);
      wr_reg(8'h71);
      @(negedge clk) trace_rst = 1'b1;
      @(negedge clk) trace_rst = 1'b0;
      chk(reg_rdata == 8'h00, "R13", reg_rdata, 8'h00);

      idle(2);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule